// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the pin-level timing of one bus machine cycle for a small 8-bit processor whose low address byte and data byte share the same pins. A client presents a cycle request: a 3-bit cycle code, a 16-bit address, a write byte and, for fetch-like cycles, a count of extra trailing T-states. The sequencer then walks the T-states one clock each. It drives the status triple, the high address byte, the shared AD lines and their enable, the address strobe, and exactly one of the three active-low strobes. It stretches the cycle with wait states while the addressed device holds READY low, captures the read byte and flags completion.

The cycle code is the status triple itself, ordered {io_m, s1, s0}. Opcode fetch is 011, memory read is 010, memory write is 001, I/O read is 110, I/O write is 101 and interrupt acknowledge is 111. Codes 000 and 100 are not cycle requests. When no cycle runs, the status outputs are released: `io_m_oe` is low, `io_m`, `s1` and `s0` read 0, and all strobes are high.

Top module: `bus_cycle_seq`

## Requirements
- R1: From T1 through the last T-state of a cycle, `io_m_oe` is 1 and {io_m,s1,s0} equals the requested cycle code without change. In idle, `io_m_oe` is 0 and {io_m,s1,s0} is 000.
- R2: `ale` is high in T1 only. In T1, `ad_out` carries address bits 7..0 with `ad_oe`=1. `a_hi` carries address bits 15..8 from T1 onward and keeps them after the cycle.
- R3: For codes 011, 010 and 110, `rd_n` is low in T2, in every wait state and in T3, and high otherwise. `ad_oe` is 0 in those states.
- R4: For codes 001 and 101, `wr_n` is low in T2, in the wait states and in T3, with `ad_oe`=1 and `ad_out` equal to the write byte. `rd_n` stays high.
- R5: For code 111, `inta_n` is low in T2, in the wait states and in T3, while `rd_n` and `wr_n` stay high. No two strobes are ever low together.
- R6: READY is sampled only on the clock edge that ends T2 and on the edge that ends each wait state. A low sample adds one wait state before T3. READY has no effect in T1, T3, T4 or later.
- R7: Cycles 010, 001, 110 and 101 last 3 T-states plus waits. Cycles 011 and 111 last 4 T-states plus waits plus the requested extra count. The extra count is clamped to MAX_EXTRA (2), so a request of 3 yields 2.
- R8: `done` is high for exactly one clock, the clock after the final T-state. For codes 011, 010, 110 and 111, `rdata` takes the value on `ad_in` at the edge ending T3. Write cycles leave `rdata` unchanged.
- R9: A request is taken only while `req_ready` is high (idle) and the code is legal. A request presented mid-cycle, or with code 000 or 100, changes nothing.
- R10: While reset is held, the block is idle with `req_ready`=1, `done`=0, `rdata`=0 and `a_hi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle code {io_m,s1,s0} |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_extra | input | 2 | Extra T-states after T4 (fetch-like cycles) |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured by the last read-type cycle |
| ready | input | 1 | Device ready; low inserts wait states |
| a_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared AD lines |
| ad_oe | output | 1 | Drive enable for the AD lines |
| ad_in | input | 8 | Value read from the AD lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| io_m_oe | output | 1 | Status outputs driven (0 means released) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The hardest situation to reach from the ports is READY behaviour at the edges of the wait window. A low READY must count only on the edge leaving T2 and on the edges leaving wait states, and must be ignored on the edges leaving T1, T3 and the decode states. The stimulus drives READY low during every state outside the window in some cycles, and programs 0 to 3 wait states per cycle by changing READY just before the deciding edge. The capture edge is pinned by placing the correct read byte on `ad_in` only during T3 and a complemented byte at all other times. Stray requests are injected mid-cycle to show they leave the running cycle untouched.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam logic [2:0] KIND_FETCH = 3'b011;
  localparam logic [2:0] KIND_MRD   = 3'b010;
  localparam logic [2:0] KIND_MWR   = 3'b001;
  localparam logic [2:0] KIND_IORD  = 3'b110;
  localparam logic [2:0] KIND_IOWR  = 3'b101;
  localparam logic [2:0] KIND_ACK   = 3'b111;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5,
    TS_TX   = 3'd6
  } tstate_e;

  function automatic logic kind_legal(input logic [2:0] k);
    return (k != 3'b000) && (k != 3'b100);
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == KIND_FETCH) || (k == KIND_MRD) || (k == KIND_IORD);
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == KIND_MWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic kind_acks(input logic [2:0] k);
    return k == KIND_ACK;
  endfunction

  function automatic logic kind_long(input logic [2:0] k);
    return (k == KIND_FETCH) || (k == KIND_ACK);
  endfunction

endpackage

// File: rtl/bus_req_latch.sv
module bus_req_latch
  import bus_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MAX_EXTRA = 2,
  parameter int EXW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [EXW-1:0] req_extra,
  output logic [2:0]    kind_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [EXW-1:0] extra_q
);

  localparam logic [EXW-1:0] EXTRA_CAP = EXW'(MAX_EXTRA);

  logic [2:0]     kind_d;
  logic [AW-1:0]  addr_d;
  logic [DW-1:0]  wdata_d;
  logic [EXW-1:0] extra_d;

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    extra_d = extra_q;
    if (load) begin
      kind_d  = req_kind;
      addr_d  = req_addr;
      wdata_d = req_wdata;
      extra_d = (req_extra > EXTRA_CAP) ? EXTRA_CAP : req_extra;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      extra_q <= '0;
    end else begin
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      extra_q <= extra_d;
    end
  end

endmodule

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
  import bus_seq_pkg::*;
#(
  parameter int EXW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_kind,
  input  logic           ready,
  input  logic           long_cycle,
  input  logic [EXW-1:0] extra,
  output logic           load,
  output tstate_e        state_q,
  output logic           done_q
);

  tstate_e        state_d;
  logic [EXW-1:0] xcnt_q;
  logic [EXW-1:0] xcnt_d;
  logic           done_d;

  always_comb begin
    state_d = state_q;
    xcnt_d  = xcnt_q;
    load    = 1'b0;
    unique case (state_q)
      TS_IDLE: begin
        if (req_valid && kind_legal(req_kind)) begin
          load    = 1'b1;
          state_d = TS_T1;
        end
      end
      TS_T1: state_d = TS_T2;
      TS_T2, TS_TW: state_d = ready ? TS_T3 : TS_TW;
      TS_T3: begin
        if (long_cycle) begin
          state_d = TS_T4;
          xcnt_d  = extra;
        end else begin
          state_d = TS_IDLE;
        end
      end
      TS_T4, TS_TX: begin
        if (xcnt_q != '0) begin
          state_d = TS_TX;
          xcnt_d  = xcnt_q - EXW'(1);
        end else begin
          state_d = TS_IDLE;
        end
      end
      default: state_d = TS_IDLE;
    endcase
  end

  assign done_d = (state_q != TS_IDLE) && (state_d == TS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      xcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      xcnt_q  <= xcnt_d;
      done_q  <= done_d;
    end
  end

  // R6: a low READY at the end of T2 or a wait state yields another wait state
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && !ready) |=> (state_q == TS_TW));

  // R6: READY high at the deciding edge moves on to T3
  assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && ready) |=> (state_q == TS_T3));

  // R9: an idle block without a legal request stays idle
  assert_idle_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_IDLE) && !(req_valid && kind_legal(req_kind))) |=> (state_q == TS_IDLE));

endmodule

// File: rtl/bus_pin_decode.sv
module bus_pin_decode
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  tstate_e       state,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          req_ready,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          inta_n,
  output logic          io_m,
  output logic          io_m_oe,
  output logic          s1,
  output logic          s0
);

  logic busy;
  logic strobe_win;

  always_comb begin
    busy       = (state != TS_IDLE);
    strobe_win = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);

    req_ready  = ~busy;
    io_m_oe    = busy;
    {io_m, s1, s0} = busy ? kind : 3'b000;
    ale        = (state == TS_T1);
    a_hi       = addr[AW-1:DW];

    rd_n       = ~(strobe_win && kind_reads(kind));
    wr_n       = ~(strobe_win && kind_writes(kind));
    inta_n     = ~(strobe_win && kind_acks(kind));

    ad_oe      = (state == TS_T1) || (strobe_win && kind_writes(kind));
    if (state == TS_T1)
      ad_out = addr[DW-1:0];
    else if (ad_oe)
      ad_out = wdata;
    else
      ad_out = '0;
  end

endmodule

// File: rtl/bus_rdata_cap.sv
module bus_rdata_cap
  import bus_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tstate_e       state,
  input  logic [2:0]    kind,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] rdata
);

  logic          cap_en;
  logic [DW-1:0] rdata_d;

  always_comb begin
    cap_en  = (state == TS_T3) && (kind_reads(kind) || kind_acks(kind));
    rdata_d = cap_en ? ad_in : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  // R8: outside T3 the captured byte never moves
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != TS_T3) |=> $stable(rdata));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MAX_EXTRA = 2,
  localparam int EXW      = (MAX_EXTRA < 1) ? 1 : $clog2(MAX_EXTRA + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [EXW-1:0]   req_extra,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rdata,
  input  logic             ready,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic             io_m,
  output logic             io_m_oe,
  output logic             s1,
  output logic             s0
);

  logic [1:0]     rsync_q;
  logic           srst_n;
  logic           load;
  tstate_e        state;
  logic [2:0]     kind_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [EXW-1:0] extra_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  bus_req_latch #(.AW(AW), .DW(DW), .MAX_EXTRA(MAX_EXTRA), .EXW(EXW)) u_latch (
    .clk(clk), .rst_n(srst_n), .load(load),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata), .req_extra(req_extra),
    .kind_q(kind_q), .addr_q(addr_q), .wdata_q(wdata_q), .extra_q(extra_q)
  );

  bus_tstate_fsm #(.EXW(EXW)) u_fsm (
    .clk(clk), .rst_n(srst_n), .req_valid(req_valid), .req_kind(req_kind),
    .ready(ready), .long_cycle(kind_long(kind_q)), .extra(extra_q),
    .load(load), .state_q(state), .done_q(done)
  );

  bus_pin_decode #(.AW(AW), .DW(DW)) u_pins (
    .state(state), .kind(kind_q), .addr(addr_q), .wdata(wdata_q),
    .req_ready(req_ready), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .io_m(io_m), .io_m_oe(io_m_oe), .s1(s1), .s0(s0)
  );

  bus_rdata_cap #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(srst_n), .state(state), .kind(kind_q),
    .ad_in(ad_in), .rdata(rdata)
  );

  // R2: the address strobe lasts a single T-state
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ale |=> !ale);

  // R1: status triple stays put for the whole cycle after T1
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (io_m_oe && !ale) |-> $stable({io_m, s1, s0}));

  // R5: at most one strobe low at a time
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({~rd_n, ~wr_n, ~inta_n}));

  // R4: write strobe only with the AD lines driven
  assert_wr_drive_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_n |-> ad_oe);

  // R8: completion pulse is one clock wide and lands in idle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> (req_ready && !$past(req_ready)));

  // R8: a write cycle keeps the last captured byte
  assert_write_keeps_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_n |=> $stable(rdata));

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata;
  logic [1:0] req_extra;
  logic       req_ready, done;
  logic [7:0] rdata;
  logic       ready;
  logic [7:0] a_hi, ad_out, ad_in;
  logic       ad_oe, ale, rd_n, wr_n, inta_n, io_m, io_m_oe, s1, s0;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_extra(req_extra),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ready(ready),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .io_m(io_m), .io_m_oe(io_m_oe), .s1(s1), .s0(s0)
  );

  typedef struct packed {
    logic ale, rd_n, wr_n, inta_n, soe;
    logic [2:0] st;
    logic adoe;
    logic [7:0] ad;
    logic [7:0] ahi;
    logic done, rreq, rdy, drv, chk;
    logic [7:0] rd;
  } snap_t;

  snap_t exq[$];
  logic [7:0] m_ahi = 8'h00;
  logic [7:0] m_rdata = 8'h00;

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
    end
  endtask

  function automatic snap_t idle_snap();
    snap_t s;
    s = '0;
    s.rd_n = 1'b1; s.wr_n = 1'b1; s.inta_n = 1'b1;
    s.ahi = m_ahi; s.rreq = 1'b1; s.rdy = 1'b1;
    return s;
  endfunction

  task automatic compare(input snap_t e);
    check("R2 ale", {7'd0, ale}, {7'd0, e.ale});
    check("R2 a_hi", a_hi, e.ahi);
    check("R3 rd_n", {7'd0, rd_n}, {7'd0, e.rd_n});
    check("R4 wr_n", {7'd0, wr_n}, {7'd0, e.wr_n});
    check("R5 inta_n", {7'd0, inta_n}, {7'd0, e.inta_n});
    check("R1 io_m_oe", {7'd0, io_m_oe}, {7'd0, e.soe});
    check("R1 status", {5'd0, io_m, s1, s0}, {5'd0, e.st});
    check("R4 ad_oe", {7'd0, ad_oe}, {7'd0, e.adoe});
    if (e.adoe) check("R4 ad_out", ad_out, e.ad);
    check("R8 done", {7'd0, done}, {7'd0, e.done});
    check("R9 req_ready", {7'd0, req_ready}, {7'd0, e.rreq});
    if (e.chk) check("R8 rdata", rdata, e.rd);
  endtask

  // one full cycle: build the expected per-clock pin picture, then drive and compare
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic [1:0] ext, input int waits, input logic [7:0] din,
                           input bit poke, input bit noise);
    snap_t s;
    int    nlen;
    int    seen;
    bit    rdk, wrk, ack, lng;
    rdk = (k == 3'b011) || (k == 3'b010) || (k == 3'b110);
    wrk = (k == 3'b001) || (k == 3'b101);
    ack = (k == 3'b111);
    lng = (k == 3'b011) || ack;
    s = idle_snap();
    s.rreq = 1'b0; s.soe = 1'b1; s.st = k; s.ahi = a[15:8]; s.rdy = !noise;
    s.ale = 1'b1; s.adoe = 1'b1; s.ad = a[7:0];
    exq.push_back(s);                                  // T1
    s.ale = 1'b0;
    s.rd_n = !rdk; s.wr_n = !wrk; s.inta_n = !ack;
    s.adoe = wrk; s.ad = wd;
    s.rdy = (waits == 0);
    exq.push_back(s);                                  // T2
    for (int i = 1; i <= waits; i++) begin
      s.rdy = (i == waits);
      exq.push_back(s);                                // wait states
    end
    s.rdy = !noise; s.drv = 1'b1;
    exq.push_back(s);                                  // T3
    s.drv = 1'b0;
    if (lng) begin
      s.rd_n = 1'b1; s.wr_n = 1'b1; s.inta_n = 1'b1; s.adoe = 1'b0;
      for (int i = 0; i < 1 + ((ext > 2'd2) ? 2 : int'(ext)); i++) exq.push_back(s);
    end
    nlen = exq.size();
    m_ahi = a[15:8];
    s = idle_snap();
    s.done = 1'b1; s.chk = 1'b1;
    s.rd = (rdk || ack) ? din : m_rdata;
    exq.push_back(s);                                  // completion clock
    if (rdk || ack) m_rdata = din;

    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; req_extra = ext;
    ad_in = ~din; ready = !noise;
    seen = -1;
    for (int idx = 0; exq.size() > 0; idx++) begin
      snap_t e;
      @(negedge clk);
      e = exq.pop_front();
      compare(e);
      if (done && seen < 0) seen = idx;
      ready = e.rdy;
      ad_in = e.drv ? din : ~din;
      if (poke && idx == 1) begin
        req_valid = 1'b1; req_kind = 3'b101; req_addr = 16'hFFFF; req_wdata = 8'h00;
      end else begin
        req_valid = 1'b0;
      end
    end
    check("R6/R7 cycle length", 8'(seen), 8'(nlen));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired after %0d clocks", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'b000; req_addr = '0;
    req_wdata = '0; req_extra = '0; ready = 1'b1; ad_in = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 req_ready", {7'd0, req_ready}, 8'd1);
    check("R10 done", {7'd0, done}, 8'd0);
    check("R10 rdata", rdata, 8'h00);
    check("R10 a_hi", a_hi, 8'h00);
    check("R10 io_m_oe", {7'd0, io_m_oe}, 8'd0);
    check("R10 strobes", {5'd0, rd_n, wr_n, inta_n}, 8'd7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare(idle_snap());

    run_cycle(3'b011, 16'h1234, 8'h00, 2'd0, 0, 8'h3A, 0, 0); // R3 R7 fetch
    run_cycle(3'b010, 16'h40A0, 8'h00, 2'd0, 2, 8'hC6, 0, 1); // R3 R6 with READY noise
    run_cycle(3'b001, 16'h2000, 8'h5C, 2'd0, 0, 8'h11, 0, 0); // R4 memory write
    run_cycle(3'b110, 16'h0081, 8'h00, 2'd0, 1, 8'h9D, 1, 0); // R3 R9 stray request mid-cycle
    run_cycle(3'b101, 16'h00FE, 8'hA5, 2'd0, 3, 8'h22, 0, 1); // R4 R6 write with waits
    run_cycle(3'b111, 16'h7F00, 8'h00, 2'd1, 0, 8'hEF, 0, 1); // R5 R7 acknowledge, one extra
    run_cycle(3'b011, 16'hBEEF, 8'h00, 2'd3, 1, 8'h77, 0, 0); // R7 extra clamped to 2

    // R9: illegal codes are not taken
    for (int j = 0; j < 2; j++) begin
      req_valid = 1'b1; req_kind = (j == 0) ? 3'b000 : 3'b100; req_addr = 16'h5555;
      @(negedge clk);
      req_valid = 1'b0;
      compare(idle_snap());
      @(negedge clk);
      compare(idle_snap());
    end

    run_cycle(3'b001, 16'h3344, 8'h0F, 2'd2, 1, 8'h66, 1, 1); // R8 write keeps rdata
    run_cycle(3'b011, 16'hFFFF, 8'h00, 2'd2, 0, 8'h01, 0, 1); // R7 two extras
    run_cycle(3'b010, 16'h0000, 8'h00, 2'd0, 0, 8'hFE, 0, 0); // R8 back-to-back read

    @(negedge clk);
    compare(idle_snap());
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule